// File: doc/BRIEF.md
# Prescaled Match/Capture Timer-Counter

This block is a 32-bit timer/counter that sits on a simple word-addressed register bus. A prescale counter divides the module clock, and each time it wraps the main counter advances by one. The main counter can instead count the rising edges, the falling edges or both edges of one of the capture inputs. Four match channels compare the main counter against their own limit. On a match a channel can flag a pending interrupt, wrap the counter to zero, halt counting, and change the level of its own external match pin. Four capture channels copy the main counter into a capture register when a chosen edge arrives on their input pin, and they can also flag an interrupt.

Software programs the prescale value, the match limits and the per-channel controls. It then sets the enable bit. It reads counters and capture values back, and it acknowledges pending events by writing ones to the pending register. The single interrupt line stays high while any pending bit is set. Capture pins pass through a two-stage synchronizer before their edges are detected.

Top module: `mc_timer`

## Requirements
- R1: In timebase mode with enable set, the prescale counter (word 4) climbs from 0 to the prescale limit (word 3). The main counter (word 2) advances once each time the prescale counter wraps, which is once every limit+1 clocks.
- R2: Control word 1: bit 0 enables counting, and bit 1 holds both the prescale counter and the main counter at zero while it is set.
- R3: Match control word 5 holds three bits per match channel n. Bit 3n is the interrupt enable and bit 3n+1 is wrap-on-match. A match is taken at an increment point where the main counter equals the match limit (words 6 to 9). With wrap set, that increment loads zero, so the count period is limit+1.
- R4: Bit 3n+2 of word 5 is stop-on-match. At the matching increment point the counter holds its value and the enable bit reads back as 0.
- R5: Pending word 0 maps match channel n to bit n and capture channel n to bit 4+n. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a new event in the same cycle wins over a clear.
- R6: `irq_o` is high exactly while at least one pending bit is set.
- R7: Capture control word 10 holds three bits per capture channel n. Bit 3n selects the rising edge, bit 3n+1 the falling edge and bit 3n+2 the interrupt. A selected edge loads the current main counter into capture word 11+n, and unselected edges leave that word unchanged.
- R8: In external match word 15, bits 3:0 are the pin levels and can be written directly. Bits 5+2n:4+2n hold the action for channel n: 0 keep, 1 low, 2 high, 3 toggle. The action is applied on each match of channel n, and `mat_o` shows the levels.
- R9: Count mode word 16: bits 1:0 = 0 selects timebase ticks, 1 rising edges, 2 falling edges and 3 both edges. Bits 3:2 select the capture input. In an edge mode only the selected input advances the counter, and the prescale counter does not move.
- R10: Registers sit 4 bytes apart in the order listed above. A read returns the addressed word on `bus_rdata_o` one clock after the request.
- R11: After reset every register, `mat_o`, `irq_o` and `bus_rdata_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock and timebase |
| rst | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Bus access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data, valid one clock after the read request |
| cap_i | input | N_CAP | Asynchronous capture / count inputs |
| mat_o | output | N_MATCH | External match pin levels |
| irq_o | output | 1 | Combined interrupt, high while any event is pending |

## Verification
The edge-rate property assumes that every capture input holds each level for at least two clocks, so that a rising edge and a falling edge never appear on consecutive cycles after synchronization. Every pin pulse in the stimulus stays high for three clocks and low for three clocks. The other properties assume only that bus writes are single-cycle requests. The bench issues each access for exactly one clock and leaves at least one idle clock between accesses. To make capture values exact regardless of synchronizer latency, the bench loads the counter with a known value while counting is disabled before it toggles any pin.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

  // Increment source selection for the main counter
  typedef enum logic [1:0] {
    CNT_TIMER = 2'd0,
    CNT_RISE  = 2'd1,
    CNT_FALL  = 2'd2,
    CNT_BOTH  = 2'd3
  } cnt_src_e;

  // Action on an external match pin when its channel matches
  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  // Fixed word indices; the rest follow from the channel counts
  localparam int REG_PEND  = 0;
  localparam int REG_CTRL  = 1;
  localparam int REG_COUNT = 2;
  localparam int REG_PSCL  = 3;
  localparam int REG_PCNT  = 4;
  localparam int REG_MCTL  = 5;
  localparam int REG_MVAL0 = 6;

endpackage

// File: rtl/tmc_edge_sync.sv
module tmc_edge_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= in_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;
  assign fall_o = ~sync_q & last_q;

  // Input rate limit: a rise is never followed directly by a fall
  AST_IN_RATE: assert property (@(posedge clk) disable iff (rst)
    (|rise_o) |=> ((fall_o & $past(rise_o)) == '0)); // R9

endmodule

// File: rtl/tmc_tick_gen.sv
module tmc_tick_gen
  import tmc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int N_CAP = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic             en_i,
  input  cnt_src_e         mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_CAP-1:0] rise_i,
  input  logic [N_CAP-1:0] fall_i,
  input  logic [CNT_W-1:0] pr_i,
  input  logic             wr_pc_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] pc_o
);

  logic [CNT_W-1:0] pc_q;
  logic             src;
  logic             wrap;

  assign wrap = (pc_q == pr_i);

  always_comb begin
    unique case (mode_i)
      CNT_TIMER: src = wrap;
      CNT_RISE:  src = rise_i[sel_i];
      CNT_FALL:  src = fall_i[sel_i];
      default:   src = rise_i[sel_i] | fall_i[sel_i];
    endcase
  end

  assign tick_o = en_i & ~hold_i & src;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      pc_q <= '0;
    end else if (wr_pc_i) begin
      pc_q <= wdata_i;
    end else if (en_i && mode_i == CNT_TIMER) begin
      pc_q <= wrap ? '0 : pc_q + 1'b1;
    end
  end

  assign pc_o = pc_q;

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (pc_q == '0)); // R2

  AST_PC_FROZEN_EDGE_MODE: assert property (@(posedge clk) disable iff (rst)
    (mode_i != CNT_TIMER && !hold_i && !wr_pc_i) |=> $stable(pc_q)); // R9

endmodule

// File: rtl/tmc_match_bank.sv
module tmc_match_bank
  import tmc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4
) (
  input  logic [CNT_W-1:0]                tc_i,
  input  logic [N_MATCH-1:0][CNT_W-1:0]   mr_i,
  input  logic [3*N_MATCH-1:0]            mcr_i,
  input  logic [2*N_MATCH-1:0]            act_i,
  input  logic                            tick_i,
  input  logic [N_MATCH-1:0]              pin_base_i,
  output logic [N_MATCH-1:0]              evt_o,
  output logic [N_MATCH-1:0]              int_o,
  output logic                            rst_hit_o,
  output logic                            stop_hit_o,
  output logic [N_MATCH-1:0]              pin_o
);

  logic [N_MATCH-1:0] wrap_en, stop_en;

  for (genvar n = 0; n < N_MATCH; n++) begin : g_ch
    pin_act_e act;
    assign act        = pin_act_e'(act_i[2*n +: 2]);
    assign evt_o[n]   = tick_i & (tc_i == mr_i[n]);
    assign int_o[n]   = evt_o[n] & mcr_i[3*n];
    assign wrap_en[n] = mcr_i[3*n+1];
    assign stop_en[n] = mcr_i[3*n+2];

    always_comb begin
      pin_o[n] = pin_base_i[n];
      if (evt_o[n]) begin
        unique case (act)
          PIN_LOW:  pin_o[n] = 1'b0;
          PIN_HIGH: pin_o[n] = 1'b1;
          PIN_FLIP: pin_o[n] = ~pin_base_i[n];
          default:  pin_o[n] = pin_base_i[n];
        endcase
      end
    end
  end

  assign rst_hit_o  = |(evt_o & wrap_en);
  assign stop_hit_o = |(evt_o & stop_en);

endmodule

// File: rtl/tmc_capture_bank.sv
module tmc_capture_bank #(
  parameter int CNT_W = 32,
  parameter int N_CAP = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_CAP-1:0]            rise_i,
  input  logic [N_CAP-1:0]            fall_i,
  input  logic [3*N_CAP-1:0]          ccr_i,
  input  logic [CNT_W-1:0]            tc_i,
  output logic [N_CAP-1:0][CNT_W-1:0] cr_o,
  output logic [N_CAP-1:0]            int_o
);

  logic [N_CAP-1:0][CNT_W-1:0] cr_q;
  logic [N_CAP-1:0]            load;

  for (genvar n = 0; n < N_CAP; n++) begin : g_ch
    assign load[n]  = (rise_i[n] & ccr_i[3*n]) | (fall_i[n] & ccr_i[3*n+1]);
    assign int_o[n] = load[n] & ccr_i[3*n+2];

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
      load[n] |=> (cr_q[n] == $past(tc_i))); // R7

    AST_CAP_QUIET: assert property (@(posedge clk) disable iff (rst)
      !load[n] |=> $stable(cr_q[n])); // R7
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q <= '0;
    end else begin
      for (int n = 0; n < N_CAP; n++) begin
        if (load[n]) cr_q[n] <= tc_i;
      end
    end
  end

  assign cr_o = cr_q;

endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import tmc_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int N_MATCH = 4,
  parameter int N_CAP   = 4,
  parameter int ADDR_W  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_en_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [CNT_W-1:0]   bus_wdata_i,
  output logic [CNT_W-1:0]   bus_rdata_o,
  input  logic [N_CAP-1:0]   cap_i,
  output logic [N_MATCH-1:0] mat_o,
  output logic               irq_o
);

  localparam int SEL_W   = (N_CAP > 1) ? $clog2(N_CAP) : 1;
  localparam int IR_W    = N_MATCH + N_CAP;
  localparam int WI_W    = ADDR_W - 2;
  localparam int R_CCTL  = REG_MVAL0 + N_MATCH;
  localparam int R_CAP0  = R_CCTL + 1;
  localparam int R_EXTM  = R_CAP0 + N_CAP;
  localparam int R_CMODE = R_EXTM + 1;

  // ---------------- bus decode ----------------
  logic [WI_W-1:0] widx;
  logic            wr;
  logic            addr_lo_unused;
  logic            wr_pend, wr_ctl, wr_tc, wr_pr, wr_pc, wr_mcr, wr_ccr, wr_emr, wr_cm;
  logic [N_MATCH-1:0] wr_mr;

  assign widx           = bus_addr_i[ADDR_W-1:2];
  assign addr_lo_unused = ^bus_addr_i[1:0];
  assign wr             = bus_en_i & bus_we_i;
  assign wr_pend = wr && (widx == WI_W'(REG_PEND));
  assign wr_ctl  = wr && (widx == WI_W'(REG_CTRL));
  assign wr_tc   = wr && (widx == WI_W'(REG_COUNT));
  assign wr_pr   = wr && (widx == WI_W'(REG_PSCL));
  assign wr_pc   = wr && (widx == WI_W'(REG_PCNT));
  assign wr_mcr  = wr && (widx == WI_W'(REG_MCTL));
  assign wr_ccr  = wr && (widx == WI_W'(R_CCTL));
  assign wr_emr  = wr && (widx == WI_W'(R_EXTM));
  assign wr_cm   = wr && (widx == WI_W'(R_CMODE));

  for (genvar n = 0; n < N_MATCH; n++) begin : g_mrdec
    assign wr_mr[n] = wr && (widx == WI_W'(REG_MVAL0 + n));
  end

  // ---------------- state ----------------
  logic [IR_W-1:0]                 ir_q, ir_d;
  logic                            en_q, crst_q;
  logic [CNT_W-1:0]                tc_q, pr_q;
  logic [3*N_MATCH-1:0]            mcr_q;
  logic [N_MATCH-1:0][CNT_W-1:0]   mr_q;
  logic [3*N_CAP-1:0]              ccr_q;
  logic [N_MATCH-1:0]              pins_q, pin_base, pin_next;
  logic [2*N_MATCH-1:0]            act_q;
  cnt_src_e                        cmode_q;
  logic [SEL_W-1:0]                csel_q;
  logic                            irq_q;
  logic [CNT_W-1:0]                rdata_q, rd_val;

  // ---------------- datapath blocks ----------------
  logic [N_CAP-1:0]              rise, fall, cap_int;
  logic [N_CAP-1:0][CNT_W-1:0]   cr;
  logic                          tick;
  logic [CNT_W-1:0]              pc;
  logic [N_MATCH-1:0]            mat_evt, mat_int;
  logic                          rst_hit, stop_hit;

  tmc_edge_sync #(.W(N_CAP)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .in_i   (cap_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmc_tick_gen #(.CNT_W(CNT_W), .N_CAP(N_CAP), .SEL_W(SEL_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .hold_i  (crst_q),
    .en_i    (en_q),
    .mode_i  (cmode_q),
    .sel_i   (csel_q),
    .rise_i  (rise),
    .fall_i  (fall),
    .pr_i    (pr_q),
    .wr_pc_i (wr_pc),
    .wdata_i (bus_wdata_i),
    .tick_o  (tick),
    .pc_o    (pc)
  );

  assign pin_base = wr_emr ? bus_wdata_i[N_MATCH-1:0] : pins_q;

  tmc_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
    .tc_i       (tc_q),
    .mr_i       (mr_q),
    .mcr_i      (mcr_q),
    .act_i      (act_q),
    .tick_i     (tick),
    .pin_base_i (pin_base),
    .evt_o      (mat_evt),
    .int_o      (mat_int),
    .rst_hit_o  (rst_hit),
    .stop_hit_o (stop_hit),
    .pin_o      (pin_next)
  );

  tmc_capture_bank #(.CNT_W(CNT_W), .N_CAP(N_CAP)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise),
    .fall_i (fall),
    .ccr_i  (ccr_q),
    .tc_i   (tc_q),
    .cr_o   (cr),
    .int_o  (cap_int)
  );

  // ---------------- control and counter ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      crst_q <= 1'b0;
    end else if (wr_ctl) begin
      en_q   <= bus_wdata_i[0];
      crst_q <= bus_wdata_i[1];
    end else if (stop_hit) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || crst_q) begin
      tc_q <= '0;
    end else if (wr_tc) begin
      tc_q <= bus_wdata_i;
    end else if (tick) begin
      if (rst_hit)       tc_q <= '0;
      else if (!stop_hit) tc_q <= tc_q + 1'b1;
    end
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pr_q    <= '0;
      mcr_q   <= '0;
      mr_q    <= '0;
      ccr_q   <= '0;
      act_q   <= '0;
      cmode_q <= CNT_TIMER;
      csel_q  <= '0;
    end else begin
      if (wr_pr)  pr_q  <= bus_wdata_i;
      if (wr_mcr) mcr_q <= bus_wdata_i[3*N_MATCH-1:0];
      if (wr_ccr) ccr_q <= bus_wdata_i[3*N_CAP-1:0];
      if (wr_emr) act_q <= bus_wdata_i[3*N_MATCH-1:N_MATCH];
      if (wr_cm) begin
        cmode_q <= cnt_src_e'(bus_wdata_i[1:0]);
        csel_q  <= bus_wdata_i[2 +: SEL_W];
      end
      for (int n = 0; n < N_MATCH; n++) begin
        if (wr_mr[n]) mr_q[n] <= bus_wdata_i;
      end
    end
  end

  // ---------------- pins, pending, interrupt ----------------
  assign ir_d = (ir_q & ~(wr_pend ? bus_wdata_i[IR_W-1:0] : '0)) | {cap_int, mat_int};

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
      ir_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pins_q <= pin_next;
      ir_q   <= ir_d;
      irq_q  <= |ir_d;
    end
  end

  // ---------------- read path ----------------
  always_comb begin
    rd_val = '0;
    if (widx == WI_W'(REG_PEND))  rd_val = CNT_W'(ir_q);
    if (widx == WI_W'(REG_CTRL))  rd_val = CNT_W'({crst_q, en_q});
    if (widx == WI_W'(REG_COUNT)) rd_val = tc_q;
    if (widx == WI_W'(REG_PSCL))  rd_val = pr_q;
    if (widx == WI_W'(REG_PCNT))  rd_val = pc;
    if (widx == WI_W'(REG_MCTL))  rd_val = CNT_W'(mcr_q);
    if (widx == WI_W'(R_CCTL))    rd_val = CNT_W'(ccr_q);
    if (widx == WI_W'(R_EXTM))    rd_val = CNT_W'({act_q, pins_q});
    if (widx == WI_W'(R_CMODE))   rd_val = CNT_W'({csel_q, cmode_q});
    for (int n = 0; n < N_MATCH; n++) begin
      if (widx == WI_W'(REG_MVAL0 + n)) rd_val = mr_q[n];
    end
    for (int n = 0; n < N_CAP; n++) begin
      if (widx == WI_W'(R_CAP0 + n)) rd_val = cr[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       rdata_q <= '0;
    else if (bus_en_i && !bus_we_i) rdata_q <= rd_val;
  end

  assign bus_rdata_o = rdata_q;
  assign mat_o       = pins_q;
  assign irq_o       = irq_q;

  // ---------------- assertions ----------------
  AST_IDLE_COUNT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!crst_q && !wr_tc && !tick) |=> $stable(tc_q)); // R1

  AST_RST_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    crst_q |=> (tc_q == '0)); // R2

  AST_WRAP_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (tick && rst_hit && !crst_q && !wr_tc) |=> (tc_q == '0)); // R3

  AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (stop_hit && !wr_ctl) |=> !en_q); // R4

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_pend |=> (($past(ir_q) & ~ir_q) == '0)); // R5

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(|{cap_int, mat_int})); // R6

  AST_PIN_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!(|mat_evt) && !wr_emr) |=> $stable(pins_q)); // R8

endmodule

// File: tb/sim_mc_timer.sv
module sim_mc_timer;

  localparam logic [6:0] A_PEND = 7'd0,  A_CTRL = 7'd4,  A_TC  = 7'd8,  A_PR  = 7'd12;
  localparam logic [6:0] A_PC   = 7'd16, A_MCR  = 7'd20, A_MR0 = 7'd24, A_CCR = 7'd40;
  localparam logic [6:0] A_CR0  = 7'd44, A_EMR  = 7'd60, A_CM  = 7'd64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ben = 1'b0, bwe = 1'b0;
  logic [6:0]  baddr = '0;
  logic [31:0] bwdata = '0;
  logic [31:0] brdata;
  logic [3:0]  cap = '0;
  logic [3:0]  mat;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  mc_timer u0 (
    .clk         (clk),
    .rst         (rst),
    .bus_en_i    (ben),
    .bus_we_i    (bwe),
    .bus_addr_i  (baddr),
    .bus_wdata_i (bwdata),
    .bus_rdata_o (brdata),
    .cap_i       (cap),
    .mat_o       (mat),
    .irq_o       (irq)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    ben = 1'b1; bwe = 1'b1; baddr = a; bwdata = d;
    @(negedge clk);
    ben = 1'b0; bwe = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    ben = 1'b1; bwe = 1'b0; baddr = a;
    @(negedge clk);
    ben = 1'b0;
    d = brdata;
  endtask

  task automatic chk_reg(string tag, logic [6:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse(int ch);
    @(negedge clk);
    cap[ch] = 1'b1;
    repeat (3) @(negedge clk);
    cap[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Restart: hold counters at zero, then enable; run k idle clocks, then
  // disable. Counting edges seen = k + 2.
  task automatic run_for(int k);
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
    repeat (k) @(negedge clk);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_reset;
    check("R11 mat_o after reset", {28'h0, mat}, 32'h0);
    check("R11 irq_o after reset", {31'h0, irq}, 32'h0);
    check("R11 rdata after reset", brdata, 32'h0);
    chk_reg("R11 pending after reset", A_PEND, 32'h0);
    chk_reg("R11 counter after reset", A_TC, 32'h0);
    chk_reg("R11 control after reset", A_CTRL, 32'h0);
  endtask

  task automatic t_prescale;
    wr(A_PR, 32'd3);
    run_for(9);                                   // 11 clocks, limit 3
    chk_reg("R1 counter after 11 clocks", A_TC, 32'd2);
    chk_reg("R1 prescale counter after 11 clocks", A_PC, 32'd3);
    wr(A_CTRL, 32'h2);                            // R2 hold clears both
    chk_reg("R2 counter held at zero", A_TC, 32'd0);
    chk_reg("R2 prescale held at zero", A_PC, 32'd0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_match_wrap;
    wr(A_PR, 32'd0);
    wr(A_MR0, 32'd4);
    wr(A_MCR, 32'h3);                             // ch0 interrupt + wrap
    run_for(10);                                  // 12 clocks, period 5
    chk_reg("R3 counter wraps with period limit+1", A_TC, 32'd2);
    chk_reg("R5 match 0 pending on bit 0", A_PEND, 32'h1);
    check("R6 irq high while pending", {31'h0, irq}, 32'h1);
    wr(A_PEND, 32'h0);
    chk_reg("R5 writing zero keeps pending", A_PEND, 32'h1);
    wr(A_PEND, 32'h1);
    chk_reg("R5 writing one clears pending", A_PEND, 32'h0);
    check("R6 irq low after clear", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_stop;
    wr(A_MR0 + 7'd4, 32'd6);
    wr(A_MCR, 32'h28);                            // ch1 interrupt + stop
    run_for(20);
    chk_reg("R4 counter halts at match limit", A_TC, 32'd6);
    chk_reg("R4 enable cleared by stop", A_CTRL, 32'h0);
    chk_reg("R5 match 1 pending on bit 1", A_PEND, 32'h2);
    wr(A_PEND, 32'hFF);
  endtask

  task automatic t_ext_match;
    wr(A_MR0,          32'd1);
    wr(A_MR0 + 7'd4,   32'd0);
    wr(A_MR0 + 7'd8,   32'd2);
    wr(A_MR0 + 7'd12,  32'd0);
    wr(A_MCR, 32'h80);                            // ch2 wrap, no interrupts
    wr(A_EMR, 32'h72A);                           // high, keep, toggle, low
    check("R8 preset levels visible", {28'h0, mat}, 32'hA);
    run_for(9);                                   // 11 clocks, period 3
    check("R8 pin actions keep/low/high/toggle", {28'h0, mat}, 32'h7);
    chk_reg("R8 external match word readback", A_EMR, 32'h727);
    chk_reg("R3 counter with period 3", A_TC, 32'd2);
    chk_reg("R5 no pending without enables", A_PEND, 32'h0);
  endtask

  task automatic t_count_mode;
    wr(A_MCR, 32'h0);
    wr(A_CCR, 32'h0);
    wr(A_CM, 32'h9);                              // rising edges of input 2
    chk_reg("R10 count mode readback", A_CM, 32'h9);
    wr(A_CTRL, 32'h2);
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 5; i++) begin
      pulse(2);
      if (i < 3) pulse(1);                        // other input ignored
    end
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk_reg("R9 rising edges of selected input", A_TC, 32'd5);
    chk_reg("R9 prescale idle in edge mode", A_PC, 32'd0);
    wr(A_CM, 32'hB);                              // both edges of input 2
    wr(A_CTRL, 32'h1);
    pulse(2);
    pulse(0);
    pulse(2);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 32'h0);
    chk_reg("R9 both edges counted", A_TC, 32'd9);
    chk_reg("R7 no capture when unselected", A_CR0 + 7'd8, 32'd0);
    wr(A_CM, 32'h0);
  endtask

  task automatic t_capture;
    wr(A_PEND, 32'hFF);
    wr(A_CCR, 32'h405);                           // ch0 rise+int, ch3 fall
    wr(A_TC, 32'd1234);
    @(negedge clk); cap[0] = 1'b1;
    repeat (4) @(negedge clk); cap[3] = 1'b1;
    repeat (4) @(negedge clk);
    wr(A_TC, 32'd777);
    @(negedge clk); cap[0] = 1'b0;
    repeat (4) @(negedge clk); cap[3] = 1'b0;
    repeat (4) @(negedge clk);
    chk_reg("R7 rising capture keeps first value", A_CR0, 32'd1234);
    chk_reg("R7 falling capture on channel 3", A_CR0 + 7'd12, 32'd777);
    chk_reg("R5 capture 0 pending on bit 4", A_PEND, 32'h10);
    check("R6 irq from capture", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_match_wrap();
    t_stop();
    t_ext_match();
    t_count_mode();
    t_capture();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule